// File: doc/BRIEF.md
# Supply Monitor Control and Reset-Cause Register

This block is the byte-wide control and status register of a microcontroller's supply-integrity logic. Software uses it to choose which voltage the threshold monitor watches (the main supply or an external sense pin) and to enable an interrupt. It reads back a hardware flag that shows whether that voltage is below threshold. Two sticky flags record why the chip last came out of reset.

The comparator output arrives asynchronously. It passes through a two-flop synchronizer and then drives the threshold flag. Every change of that flag, up or down, raises a pending interrupt when the enable is set. The CPU's handler-entry acknowledge clears the pending interrupt.

The reset-cause flags live in a power-on reset domain, so an ordinary system reset does not clear them. A low-voltage reset sets its own flag and forces the watchdog flag clear. The flag pair therefore distinguishes an external pin reset, a watchdog reset and a low-voltage reset.

Top module: `supply_guard_reg`

## Requirements
- R1: The read value is {srcSel, intEn, thrFlag, lvdFlag, 3'b000, wdgFlag}, from bit 7 down to bit 0. Writes to bits 5 and 3:1 have no effect.
- R2: A write loads bit 7 into srcSel (0 = main supply, 1 = external sense pin) and bit 6 into intEn, visible the next cycle. `monSrcSel` equals srcSel. System reset clears both bits.
- R3: While `monEnable` is 1, a change on `belowThrAsync` reaches thrFlag (read bit 5) on the third rising clock edge after the change. 1 means below threshold.
- R4: With intEn = 1, every change of thrFlag, rising or falling, sets the pending interrupt, and `irqReq` is 1 in the same cycle that thrFlag reads the new value. With intEn = 0, no interrupt is raised.
- R5: `irqReq` stays 1 until a cycle with `irqAck` = 1. It reads 0 after that cycle, with no register write needed.
- R6: `lvdRstEvt` sets lvdFlag (bit 4). Writing 0 to bit 4 clears it. Writing 1 to bit 4 leaves it unchanged.
- R7: `wdgRstEvt` sets wdgFlag (bit 0). Writing 0 to bit 0 clears it. Writing 1 leaves it unchanged. `lvdRstEvt` clears it, and this takes priority over `wdgRstEvt` in the same cycle. The pair {lvdFlag, wdgFlag} reads 00 after an external reset, 01 after a watchdog reset and 1x after a low-voltage reset.
- R8: System reset (`rstN`) leaves lvdFlag and wdgFlag unchanged. Power-on reset (`porN`) clears them.
- R9: While `monEnable` is 0, thrFlag reads 0 and no interrupt is raised.
- R10: A hardware set of a reset-cause flag wins over a software clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | System reset, active low, asynchronous |
| porN | input | 1 | Power-on reset, active low, asynchronous; clears the reset-cause flags |
| monEnable | input | 1 | Static configuration: low-voltage monitoring enabled |
| belowThrAsync | input | 1 | Asynchronous comparator output, 1 = below threshold |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read value |
| lvdRstEvt | input | 1 | One-cycle pulse: a low-voltage reset occurred |
| wdgRstEvt | input | 1 | One-cycle pulse: a watchdog reset occurred |
| irqAck | input | 1 | CPU entered the monitor interrupt handler |
| irqReq | output | 1 | Monitor interrupt request |
| monSrcSel | output | 1 | Selected monitor source, 0 = main supply, 1 = external pin |

## Verification
The assertions take the event and acknowledge inputs to be single-cycle pulses, synchronous to `clk`. They also assume `monEnable` changes only while no interrupt edge is in flight. The bench drives every input on the falling edge and holds each event high for exactly one cycle. It changes the comparator only after the previous change has settled through the synchronizer. It toggles `monEnable` only while the comparator and the flag agree.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;
  localparam int REG_W   = 8;
  localparam int SRC_BIT = 7;
  localparam int IEN_BIT = 6;
  localparam int THR_BIT = 5;
  localparam int LVD_BIT = 4;
  localparam int WDG_BIT = 0;
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic wrCtrl;
    logic srcSelNext;
    logic intEnNext;
    logic clrLvd;
    logic clrWdg;
    logic setLvd;
    logic setWdg;
    logic setPend;
    logic clrPend;
  } guardStrobe_t;
endpackage

// File: rtl/sg_ctrl.sv
module sg_ctrl
  import supply_guard_pkg::*;
#(
  parameter int STAGES = SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         monEnable,
  input  logic         belowThrAsync,
  input  logic         wrEn,
  input  logic         wrSrc,
  input  logic         wrIen,
  input  logic         wrLvd,
  input  logic         wrWdg,
  input  logic         lvdRstEvt,
  input  logic         wdgRstEvt,
  input  logic         irqAck,
  input  logic         intEn,
  output guardStrobe_t strobe,
  output logic         thrFlag
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] syncQ;
  logic              toggle;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= belowThrAsync;
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[STAGES-2:0], belowThrAsync};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)          thrFlag <= 1'b0;
    else if (monEnable) thrFlag <= syncQ[TOP];
    else                thrFlag <= 1'b0;

  assign toggle = monEnable && (syncQ[TOP] != thrFlag);

  always_comb begin
    strobe            = '0;
    strobe.wrCtrl     = wrEn;
    strobe.srcSelNext = wrSrc;
    strobe.intEnNext  = wrIen;
    strobe.clrLvd     = wrEn && !wrLvd;
    strobe.clrWdg     = wrEn && !wrWdg;
    strobe.setLvd     = lvdRstEvt;
    strobe.setWdg     = wdgRstEvt;
    strobe.setPend    = toggle && intEn;
    strobe.clrPend    = irqAck;
  end

  // R9
  thr_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !monEnable |=> !thrFlag);

  // R3
  thr_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (monEnable && syncQ[TOP]) |=> (thrFlag || !monEnable));
endmodule

// File: rtl/sg_data.sv
module sg_data
  import supply_guard_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         porN,
  input  guardStrobe_t strobe,
  output logic         srcSel,
  output logic         intEn,
  output logic         lvdFlag,
  output logic         wdgFlag,
  output logic         pending
);
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      srcSel  <= 1'b0;
      intEn   <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (strobe.wrCtrl) begin
        srcSel <= strobe.srcSelNext;
        intEn  <= strobe.intEnNext;
      end
      if (strobe.setPend)      pending <= 1'b1;
      else if (strobe.clrPend) pending <= 1'b0;
    end

  always_ff @(posedge clk or negedge porN)
    if (!porN) begin
      lvdFlag <= 1'b0;
      wdgFlag <= 1'b0;
    end else begin
      if (strobe.setLvd)      lvdFlag <= 1'b1;
      else if (strobe.clrLvd) lvdFlag <= 1'b0;
      if (strobe.setLvd)      wdgFlag <= 1'b0;
      else if (strobe.setWdg) wdgFlag <= 1'b1;
      else if (strobe.clrWdg) wdgFlag <= 1'b0;
    end

  // R7
  lvd_over_wdg_chk: assert property (@(posedge clk) disable iff (!porN)
    strobe.setLvd |=> (lvdFlag && !wdgFlag));

  // R6
  lvd_clear_chk: assert property (@(posedge clk) disable iff (!porN)
    (strobe.clrLvd && !strobe.setLvd) |=> !lvdFlag);

  // R4
  pend_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setPend |=> pending);

  // R5
  pend_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrPend && !strobe.setPend) |=> !pending);
endmodule

// File: rtl/supply_guard_reg.sv
module supply_guard_reg
  import supply_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             porN,
  input  logic             monEnable,
  input  logic             belowThrAsync,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             lvdRstEvt,
  input  logic             wdgRstEvt,
  input  logic             irqAck,
  output logic             irqReq,
  output logic             monSrcSel
);
  guardStrobe_t strobe;
  logic srcSel, intEn, thrFlag, lvdFlag, wdgFlag, pending;
  logic unusedWrBits;

  assign unusedWrBits = ^{wrData[THR_BIT], wrData[3:1]};

  sg_ctrl #(.STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .monEnable(monEnable),
    .belowThrAsync(belowThrAsync), .wrEn(wrEn),
    .wrSrc(wrData[SRC_BIT]), .wrIen(wrData[IEN_BIT]),
    .wrLvd(wrData[LVD_BIT]), .wrWdg(wrData[WDG_BIT]),
    .lvdRstEvt(lvdRstEvt), .wdgRstEvt(wdgRstEvt), .irqAck(irqAck),
    .intEn(intEn), .strobe(strobe), .thrFlag(thrFlag)
  );

  sg_data u_data (
    .clk(clk), .rstN(rstN), .porN(porN), .strobe(strobe),
    .srcSel(srcSel), .intEn(intEn), .lvdFlag(lvdFlag),
    .wdgFlag(wdgFlag), .pending(pending)
  );

  always_comb begin
    rdData          = '0;
    rdData[SRC_BIT] = srcSel;
    rdData[IEN_BIT] = intEn;
    rdData[THR_BIT] = thrFlag;
    rdData[LVD_BIT] = lvdFlag;
    rdData[WDG_BIT] = wdgFlag;
  end

  assign irqReq    = pending;
  assign monSrcSel = srcSel;

  // R8
  cause_keep_chk: assert property (@(posedge clk) disable iff (!porN)
    (!rstN && !lvdRstEvt && !wdgRstEvt && !wrEn) |=> $stable(rdData[LVD_BIT]));
endmodule

// File: tb/supply_guard_reg_bench.sv
module supply_guard_reg_bench;
  logic clk = 1'b0;
  logic rstN, porN, monEnable, cmpIn, wrEn, lvdEvt, wdgEvt, ack;
  logic [7:0] wrData, rdData;
  logic irqReq, monSrcSel;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  supply_guard_reg u_supply_guard_reg (
    .clk(clk), .rstN(rstN), .porN(porN), .monEnable(monEnable),
    .belowThrAsync(cmpIn), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .lvdRstEvt(lvdEvt), .wdgRstEvt(wdgEvt), .irqAck(ack),
    .irqReq(irqReq), .monSrcSel(monSrcSel)
  );

  // row: wrEn, wrData[7:0], lvdEvt, wdgEvt, expRd[7:0], expIrq
  localparam int NV = 11;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 8'hC0, 1'b0, 1'b0, 8'hC0, 1'b0},  // R2 control write
    {1'b1, 8'hFF, 1'b0, 1'b0, 8'hC0, 1'b0},  // R1 R6 R7 ones ignored
    {1'b0, 8'h00, 1'b0, 1'b1, 8'hC1, 1'b0},  // R7 watchdog set
    {1'b0, 8'h00, 1'b1, 1'b0, 8'hD0, 1'b0},  // R7 low-voltage clears wdg
    {1'b0, 8'h00, 1'b0, 1'b1, 8'hD1, 1'b0},  // R7
    {1'b1, 8'hD0, 1'b0, 1'b0, 8'hD0, 1'b0},  // R7 write 0 clears wdg
    {1'b1, 8'h41, 1'b0, 1'b0, 8'h40, 1'b0},  // R6 write 0 clears lvd
    {1'b1, 8'h00, 1'b0, 1'b1, 8'h01, 1'b0},  // R10 set beats clear
    {1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0},  // R7
    {1'b1, 8'h00, 1'b1, 1'b0, 8'h10, 1'b0},  // R10 lvd set beats clear
    {1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0}   // R6
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 0; porN = 0; monEnable = 1; cmpIn = 0; wrEn = 0;
    wrData = 0; lvdEvt = 0; wdgEvt = 0; ack = 0;
    tick(2);
    rstN = 1; porN = 1;
    tick(1);
    check("R1 reset rd", rdData, 8'h00);
    check("R5 reset irq", {7'b0, irqReq}, 8'h00);
    check("R2 reset src", {7'b0, monSrcSel}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      {wrEn, wrData, lvdEvt, wdgEvt} = VEC[i][19:9];
      tick(1);
      wrEn = 0; lvdEvt = 0; wdgEvt = 0;
      check($sformatf("R1 R6 R7 vec%0d rd", i), rdData, VEC[i][8:1]);
      check($sformatf("R4 vec%0d irq", i), {7'b0, irqReq}, {7'b0, VEC[i][0]});
      if (i == 0) check("R2 src out", {7'b0, monSrcSel}, 8'h01);
    end

    // R8: system reset keeps cause flags, power-on reset clears them
    wrEn = 1; wrData = 8'hC0; wdgEvt = 1;
    tick(1);
    wrEn = 0; wdgEvt = 0;
    check("R7 setup", rdData, 8'hC1);
    rstN = 0;
    tick(1);
    rstN = 1;
    tick(1);
    check("R8 survive rstN", rdData, 8'h01);
    porN = 0;
    tick(1);
    porN = 1;
    tick(1);
    check("R8 porN clears", rdData, 8'h00);

    // R3 R4: rising toggle after synchronizer
    wrEn = 1; wrData = 8'h40;
    tick(1);
    wrEn = 0;
    cmpIn = 1;
    tick(2);
    check("R3 not yet", rdData, 8'h40);
    tick(1);
    check("R3 flag set", rdData, 8'h60);
    check("R4 rise irq", {7'b0, irqReq}, 8'h01);
    tick(2);
    check("R5 held", {7'b0, irqReq}, 8'h01);
    ack = 1;
    tick(1);
    ack = 0;
    check("R5 ack clears", {7'b0, irqReq}, 8'h00);
    cmpIn = 0;
    tick(3);
    check("R3 flag clear", rdData, 8'h40);
    check("R4 fall irq", {7'b0, irqReq}, 8'h01);
    ack = 1;
    tick(1);
    ack = 0;
    check("R5 ack 2", {7'b0, irqReq}, 8'h00);

    // R4: disabled interrupt
    wrEn = 1; wrData = 8'h00;
    tick(1);
    wrEn = 0;
    cmpIn = 1;
    tick(4);
    check("R4 disabled rd", rdData, 8'h20);
    check("R4 disabled irq", {7'b0, irqReq}, 8'h00);

    // R9: monitor disabled
    monEnable = 0;
    tick(1);
    wrEn = 1; wrData = 8'h40;
    tick(1);
    wrEn = 0;
    check("R9 flag zero", rdData, 8'h40);
    check("R9 no irq", {7'b0, irqReq}, 8'h00);
    cmpIn = 0;
    tick(4);
    cmpIn = 1;
    tick(4);
    check("R9 still zero", rdData, 8'h40);
    check("R9 still no irq", {7'b0, irqReq}, 8'h00);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule